// File: doc/BRIEF.md
# CEC receive frame queue

This block holds complete CEC frames that a line decoder has already assembled, until a host has read them. Each record keeps the header byte, the opcode byte, up to fourteen operand bytes, the operand count and a flag marking a frame that was received with an error. The decoder offers one frame per cycle on a parallel frame port with a valid strobe. The queue takes the frame if it has room and drops it otherwise.

The host sees the oldest frame, the head, through a word-addressed register bus with byte addresses. It reads a packed status word, then the header, the opcode and as many operand words as the status word reports. It then writes the control register to discard the head frame, or to empty the whole queue. Both commands take a fixed number of cycles. Their control bits read as 1 until the command has taken effect.

An interrupt status register records two events: the queue going from empty to holding a frame, and a frame lost because the queue was full. An enable register decides which of these events drive the interrupt output.

Top module: `cec_rxq_top`

## Requirements
- R1: After reset the status word, the control register, the interrupt status register and the enable register all read 0, and `irq_o` is low.
- R2: The status word at byte address 0x00 holds the head frame's operand count in bits 3:0, the number of queued frames in bits 6:4 and the head frame's error flag in bit 7. The header and opcode are not counted in bits 3:0. An empty queue reads 0.
- R3: An incoming operand count above 14 is stored as 14.
- R4: The header reads at 0x04, the opcode at 0x08 and operand i at 0x40+4*i. An operand index at or beyond the head frame's count reads 0, all of these registers read 0 while the queue is empty, and unmapped addresses read 0.
- R5: Writing 0b01 to bits 1:0 of the control register at 0x0C starts a pop. Bit 0 reads 1 for exactly 2 cycles. When it clears, the head frame is gone. A pop on an empty queue changes nothing else.
- R6: Writing 0b11 starts a flush. Bits 1:0 both read 1 for exactly 2 cycles. When they clear, every frame held before the completing clock edge is gone. A frame that arrives on that same edge is kept.
- R7: Control writes made while a pop or flush is in progress are ignored, and so is the value 0b10.
- R8: The queue holds 4 frames. A frame that arrives while 4 are held is dropped, and bit 2 (overflow) of the interrupt status register at 0x10 is set.
- R9: Bit 1 of the interrupt status register is set on the cycle the queue goes from empty to non-empty. Writing 1 to a status bit clears it. A set event in the same cycle as a clear wins.
- R10: `irq_o` is the OR of interrupt status bits 1 and 2, each ANDed with the same bit of the enable register at 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Frame strobe, one frame per cycle |
| rx_header | input | 8 | Header byte of the offered frame |
| rx_opcode | input | 8 | Opcode byte of the offered frame |
| rx_nops | input | 4 | Operand count of the offered frame |
| rx_error | input | 1 | Frame was received with an error |
| rx_ops | input | 112 | Operand bytes, operand i in bits 8i+7:8i |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a new frame arriving on the exact clock edge where a flush completes. The bench counts cycles from the control write and drives the frame strobe in the second cycle after it. The same approach makes a status-bit clear coincide with an empty-to-non-empty event, and makes control writes land inside a busy window. The behavioural model in the bench decides the expected content of every register on every clock.

// File: rtl/cec_rxq_pkg.sv
package cec_rxq_pkg;
  localparam int MAX_OPS = 14;
  localparam int NOPS_W  = 4;

  // Word indices of the register map (byte address = index * 4)
  localparam logic [5:0] W_STAT  = 6'd0;
  localparam logic [5:0] W_HDR   = 6'd1;
  localparam logic [5:0] W_OPC   = 6'd2;
  localparam logic [5:0] W_CTRL  = 6'd3;
  localparam logic [5:0] W_ISTAT = 6'd4;
  localparam logic [5:0] W_IEN   = 6'd5;
  localparam logic [5:0] W_OPS   = 6'd16;

  localparam int IB_NE  = 1;
  localparam int IB_OVF = 2;

  typedef struct packed {
    logic [7:0]           hdr;
    logic [7:0]           opc;
    logic [NOPS_W-1:0]    nops;
    logic                 err;
    logic [MAX_OPS*8-1:0] ops;
  } rx_frame_t;

  function automatic logic [NOPS_W-1:0] clamp_nops(input logic [NOPS_W-1:0] n);
    return (int'(n) > MAX_OPS) ? NOPS_W'(MAX_OPS) : n;
  endfunction

  function automatic logic [7:0] pack_status(input logic [NOPS_W-1:0] nops,
                                             input logic [2:0] frames,
                                             input logic err);
    return {err, frames, nops};
  endfunction

  function automatic logic [7:0] pick_operand(input logic [MAX_OPS*8-1:0] ops,
                                              input logic [NOPS_W-1:0] nops,
                                              input logic [5:0] idx);
    if (int'(idx) < int'(nops) && int'(idx) < MAX_OPS)
      return ops[int'(idx)*8 +: 8];
    return 8'h00;
  endfunction
endpackage

// File: rtl/cec_rxq_store.sv
module cec_rxq_store
  import cec_rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_i,
  input  rx_frame_t                      frame_i,
  input  logic                           pop_i,
  input  logic                           flush_i,
  output rx_frame_t                      head_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic                           accept_o,
  output logic                           drop_o,
  output logic                           rise_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  rx_frame_t          mem [DEPTH];
  logic [PTR_W-1:0]   rd_ptr, wr_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0]   count, count_nxt, base;
  logic               full;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
  endfunction

  assign full     = (int'(count) == DEPTH);
  assign accept_o = push_i && !full;
  assign drop_o   = push_i && full;

  always_comb begin
    base       = count;
    rd_ptr_nxt = rd_ptr;
    if (flush_i) begin
      base       = '0;
      rd_ptr_nxt = wr_ptr;
    end else if (pop_i && count != '0) begin
      base       = count - 1'b1;
      rd_ptr_nxt = step(rd_ptr);
    end
    count_nxt = base + CNT_W'(accept_o);
  end

  assign rise_o = (count == '0) && (count_nxt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
      if (accept_o) wr_ptr <= step(wr_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (accept_o) mem[wr_ptr] <= frame_i;
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count;

  assert_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_o) <= DEPTH);
  assert_drop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_o && !pop_i && !flush_i) |=> (count_o == $past(count_o)));
endmodule

// File: rtl/cec_rxq_seq.sv
module cec_rxq_seq #(
  parameter int OP_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [1:0] cmd_i,
  output logic       pop_o,
  output logic       flush_o,
  output logic       busy_o,
  output logic       is_flush_o
);
  localparam int CW = $clog2(OP_CYC+1);

  logic [CW-1:0] cnt;
  logic          fl_q;
  logic          start_pop, start_flush, done;

  assign busy_o      = (cnt != '0);
  assign done        = (cnt == CW'(1));
  assign start_pop   = wr_i && !busy_o && (cmd_i == 2'b01);
  assign start_flush = wr_i && !busy_o && (cmd_i == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      fl_q <= 1'b0;
    end else if (start_pop || start_flush) begin
      cnt  <= CW'(OP_CYC);
      fl_q <= start_flush;
    end else if (busy_o) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign pop_o      = done && !fl_q;
  assign flush_o    = done && fl_q;
  assign is_flush_o = busy_o && fl_q;

  assert_one_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_o, flush_o}));
  assert_idle_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_o || flush_o) |=> !busy_o);
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !pop_o && !flush_o) |=> busy_o);
endmodule

// File: rtl/cec_rxq_irq.sv
module cec_rxq_irq
  import cec_rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ne_evt,
  input  logic       ovf_evt,
  input  logic       clr_wr,
  input  logic       en_wr,
  input  logic [7:0] wbits,
  output logic [7:0] stat_o,
  output logic [7:0] en_o,
  output logic       irq_o
);
  logic ne_q, ovf_q, en_ne, en_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ne_q   <= 1'b0;
      ovf_q  <= 1'b0;
      en_ne  <= 1'b0;
      en_ovf <= 1'b0;
    end else begin
      ne_q  <= ne_evt  || (ne_q  && !(clr_wr && wbits[IB_NE]));
      ovf_q <= ovf_evt || (ovf_q && !(clr_wr && wbits[IB_OVF]));
      if (en_wr) begin
        en_ne  <= wbits[IB_NE];
        en_ovf <= wbits[IB_OVF];
      end
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[IB_NE]  = ne_q;
    stat_o[IB_OVF] = ovf_q;
    en_o           = '0;
    en_o[IB_NE]    = en_ne;
    en_o[IB_OVF]   = en_ovf;
  end

  assign irq_o = |(stat_o & en_o);

  assert_ne_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ne_evt |=> stat_o[IB_NE]);
  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat_o[IB_OVF]);
endmodule

// File: rtl/cec_rxq_top.sv
module cec_rxq_top
  import cec_rxq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int OP_CYC = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_header,
  input  logic [7:0]             rx_opcode,
  input  logic [3:0]             rx_nops,
  input  logic                   rx_error,
  input  logic [MAX_OPS*8-1:0]   rx_ops,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   irq_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  rx_frame_t        in_frame, head;
  logic [CNT_W-1:0] count;
  logic             accept, drop, rise, empty;
  logic             pop_go, flush_go, busy, busy_fl;
  logic [7:0]       stat, en;
  logic [5:0]       word;
  logic [5:0]       op_idx;
  logic             wr_ctrl, wr_istat, wr_ien;
  logic             unused_bits;

  assign word        = 6'(bus_addr[ADDR_W-1:2]);
  assign op_idx      = word - W_OPS;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:8]};
  assign wr_ctrl     = bus_wr && (word == W_CTRL);
  assign wr_istat    = bus_wr && (word == W_ISTAT);
  assign wr_ien      = bus_wr && (word == W_IEN);

  always_comb begin
    in_frame.hdr  = rx_header;
    in_frame.opc  = rx_opcode;
    in_frame.nops = clamp_nops(rx_nops);
    in_frame.err  = rx_error;
    in_frame.ops  = rx_ops;
  end

  cec_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_i(rx_valid), .frame_i(in_frame),
    .pop_i(pop_go), .flush_i(flush_go), .head_o(head), .count_o(count),
    .accept_o(accept), .drop_o(drop), .rise_o(rise)
  );

  cec_rxq_seq #(.OP_CYC(OP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl), .cmd_i(bus_wdata[1:0]),
    .pop_o(pop_go), .flush_o(flush_go), .busy_o(busy), .is_flush_o(busy_fl)
  );

  cec_rxq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ne_evt(rise), .ovf_evt(drop),
    .clr_wr(wr_istat), .en_wr(wr_ien), .wbits(bus_wdata[7:0]),
    .stat_o(stat), .en_o(en), .irq_o(irq_o)
  );

  assign empty = (count == '0);

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_STAT:  if (!empty) bus_rdata[7:0] = pack_status(head.nops, 3'(count), head.err);
      W_HDR:   if (!empty) bus_rdata[7:0] = head.hdr;
      W_OPC:   if (!empty) bus_rdata[7:0] = head.opc;
      W_CTRL:  bus_rdata[1:0] = {busy_fl, busy};
      W_ISTAT: bus_rdata[7:0] = stat;
      W_IEN:   bus_rdata[7:0] = en;
      default: begin
        if (!empty && word >= W_OPS && int'(op_idx) < MAX_OPS)
          bus_rdata[7:0] = pick_operand(head.ops, head.nops, op_idx);
      end
    endcase
  end

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(stat & en)));
  assert_accept_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pop_go && !flush_go) |=> (count == $past(count) + 1'b1));
endmodule

// File: tb/cec_rxq_top_test.sv
module cec_rxq_top_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_header = '0, rx_opcode = '0;
  logic [3:0]   rx_nops = '0;
  logic         rx_error = 1'b0;
  logic [111:0] rx_ops = '0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq_o;

  int checks = 0, bad = 0, cycles = 0;

  cec_rxq_top uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_header(rx_header),
    .rx_opcode(rx_opcode), .rx_nops(rx_nops), .rx_error(rx_error), .rx_ops(rx_ops),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  typedef struct { int hdr; int opc; int nops; int err; int ops[14]; } mf_t;
  mf_t q[$];
  int  mbusy = 0, mfl = 0, mne = 0, movf = 0, men = 0;
  int  sz0, w;
  mf_t nf;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mbusy = 0; mfl = 0; mne = 0; movf = 0; men = 0;
    end else begin
      sz0 = q.size();
      w = int'(bus_addr) / 4;
      if (mbusy == 1) begin
        if (mfl != 0) q.delete();
        else if (q.size() > 0) void'(q.pop_front());
      end
      if (rx_valid && sz0 < 4) begin
        nf.hdr = rx_header; nf.opc = rx_opcode; nf.err = rx_error;
        nf.nops = (rx_nops > 14) ? 14 : int'(rx_nops);
        for (int i = 0; i < 14; i++) nf.ops[i] = int'(rx_ops[i*8 +: 8]);
        q.push_back(nf);
      end
      if (bus_wr && w == 4) begin
        if (bus_wdata[1]) mne = 0;
        if (bus_wdata[2]) movf = 0;
      end
      if (sz0 == 0 && q.size() > 0) mne = 1;
      if (rx_valid && sz0 >= 4) movf = 1;
      if (bus_wr && w == 5) men = int'(bus_wdata[2:0]) & 6;
      if (mbusy > 0) mbusy--;
      else if (bus_wr && w == 3) begin
        if (bus_wdata[1:0] == 2'b11) begin mbusy = 2; mfl = 1; end
        else if (bus_wdata[1:0] == 2'b01) begin mbusy = 2; mfl = 0; end
      end
    end
  end

  function automatic int model_read(int a);
    int wd = a / 4;
    int n = q.size();
    if (wd == 0) return (n > 0) ? (q[0].nops | (n << 4) | (q[0].err << 7)) : 0;
    if (wd == 1) return (n > 0) ? q[0].hdr : 0;
    if (wd == 2) return (n > 0) ? q[0].opc : 0;
    if (wd == 3) return ((mbusy > 0) ? 1 : 0) | ((mbusy > 0 && mfl != 0) ? 2 : 0);
    if (wd == 4) return (mne << 1) | (movf << 2);
    if (wd == 5) return men;
    if (wd >= 16 && wd < 30 && n > 0 && (wd - 16) < q[0].nops) return q[0].ops[wd-16];
    return 0;
  endfunction

  function automatic string tag_of(int a);
    int wd = a / 4;
    if (wd == 0) return "R2";
    if (wd == 3) return "R5";
    if (wd == 4) return "R9";
    if (wd == 5) return "R10";
    return "R4";
  endfunction

  function automatic int model_irq();
    return (((mne << 1) | (movf << 2)) & men) != 0 ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(tag_of(int'(bus_addr)), int'(bus_rdata), model_read(int'(bus_addr)));
      check("R10", int'(irq_o), model_irq());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; checks++;
      $display("FAIL R1 watchdog actual=%0d expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(negedge clk); #1; endtask

  task automatic bwrite(int a, int d);
    bus_addr = 8'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic push(int h, int o, int n, int e, int seed, bit wr = 0, int a = 0, int d = 0);
    rx_valid = 1'b1; rx_header = 8'(h); rx_opcode = 8'(o);
    rx_nops = 4'(n); rx_error = e[0];
    for (int i = 0; i < 14; i++) rx_ops[i*8 +: 8] = 8'(seed + i);
    if (wr) begin bus_addr = 8'(a); bus_wdata = 32'(d); bus_wr = 1'b1; end
    tick();
    rx_valid = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd_expect(int a, int exp, string req);
    bus_addr = 8'(a); #2;
    check(req, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    rd_expect(8'h00, 0, "R1"); rd_expect(8'h0C, 0, "R1");
    rd_expect(8'h10, 0, "R1"); rd_expect(8'h14, 0, "R1");
    check("R1", int'(irq_o), 0);
    rd_expect(8'h04, 0, "R4");
    tick();
    bwrite(8'h14, 6);
    // first frame: 2 operands
    push(8'h40, 8'h82, 2, 0, 8'h10);
    rd_expect(8'h00, 8'h12, "R2"); rd_expect(8'h04, 8'h40, "R4");
    rd_expect(8'h08, 8'h82, "R4"); rd_expect(8'h44, 8'h11, "R4");
    rd_expect(8'h48, 0, "R4");     rd_expect(8'h3C, 0, "R4");
    check("R9", int'(irq_o), 1);
    tick();
    bwrite(8'h10, 2);
    check("R9", int'(irq_o), 0);
    // fill up, clamp, overflow
    push(8'h4F, 8'h36, 14, 1, 8'hA0);
    push(8'h01, 8'h90, 15, 0, 8'h50);
    push(8'h02, 8'h8F, 0, 0, 8'h00);
    check("R8", int'(irq_o), 0);
    push(8'h03, 8'h44, 1, 0, 8'h70);
    rd_expect(8'h00, 8'h42, "R8"); rd_expect(8'h10, 4, "R8");
    check("R10", int'(irq_o), 1);
    tick();
    // pop with a stray control write during busy
    bwrite(8'h0C, 1);
    rd_expect(8'h0C, 1, "R5");
    bwrite(8'h0C, 3);
    rd_expect(8'h0C, 1, "R7");
    tick();
    rd_expect(8'h0C, 0, "R5");
    rd_expect(8'h00, 8'hBE, "R5"); rd_expect(8'h74, 8'hAD, "R4");
    tick();
    bwrite(8'h0C, 1); tick(); tick();
    rd_expect(8'h00, 8'h2E, "R3");
    rd_expect(8'h78, 0, "R3");
    tick();
    // value 0b10 ignored
    bwrite(8'h0C, 2);
    rd_expect(8'h0C, 0, "R7"); rd_expect(8'h00, 8'h2E, "R7");
    tick();
    // flush, with a frame arriving on the completing edge
    bwrite(8'h0C, 3);
    rd_expect(8'h0C, 3, "R6");
    tick();
    push(8'h0E, 8'h04, 3, 0, 8'h20);
    rd_expect(8'h0C, 0, "R6"); rd_expect(8'h00, 8'h13, "R6");
    rd_expect(8'h04, 8'h0E, "R6");
    tick();
    // pop to empty, then pop on empty
    bwrite(8'h0C, 1); tick(); tick();
    rd_expect(8'h00, 0, "R5"); rd_expect(8'h04, 0, "R4");
    bwrite(8'h0C, 1); tick(); tick();
    rd_expect(8'h00, 0, "R5");
    bwrite(8'h10, 6);
    check("R9", int'(irq_o), 0);
    // set wins over a same-cycle clear
    push(8'h11, 8'h22, 1, 0, 8'h33, 1'b1, 8'h10, 2);
    rd_expect(8'h10, 2, "R9");
    check("R9", int'(irq_o), 1);
    bwrite(8'h14, 4);
    check("R10", int'(irq_o), 0);
    repeat (3) tick();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule